// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps a record of why the system was last reset. Three causes are tracked: a power-on event, a watchdog time-out, and a hard fault. A hard fault is an instruction fetch whose address lies at or beyond the configured size of program memory. The block also turns a hard fault or a watchdog request into a one-cycle system reset request. Each flag has its own rule for which resets leave it in place.

The power-on input is the block's only reset. Its flops are not cleared by the resets the block requests itself, so the flags carry across those resets and software can read them afterwards. A small register bus reads the flags and clears them.

A hard-fault fetch is handled in one of three ways:
- If the hard-fault interrupt enable is high, the block raises an interrupt pulse. It sets no flag and requests no reset.
- If the interrupt enable is low but debug mode is active with debug enable low, the block sets the hard-fault flag and requests no reset.
- In every other case, the block sets the flag and requests a reset.

A two-state sequencer drives the reset request. `SEQ_RUN` is the idle state. It moves to `SEQ_FIRE` when a watchdog request or an unsuppressed hard fault arrives, and stays in `SEQ_RUN` otherwise. `SEQ_FIRE` always returns to `SEQ_RUN` after one cycle.

Top module: `reset_cause_unit`

## Requirements
- R1: While `por_i` is high, and after it falls, the power-on flag reads 1 and the watchdog and hard-fault flags read 0. `sys_rst_o` and `hf_irq_o` read 0 in this state.
- R2: A valid fetch with `fetch_addr_i >= mem_size_i` and `hfie_i` low, and not suppressed by R3, sets the hard-fault flag. At the same clock edge it raises `sys_rst_o`, and `sys_rst_o` stays high for exactly one cycle.
- R3: When `dbg_mode_i` is 1 and `dbg_en_i` is 0, the R2 fetch sets the hard-fault flag only, and `sys_rst_o` stays 0. When `dbg_en_i` is 1, the reset is requested as in R2.
- R4: When `hfie_i` is 1, an out-of-range fetch raises `hf_irq_o` for exactly one cycle, starting at the next edge. It leaves the hard-fault flag and `sys_rst_o` unchanged.
- R5: A fetch below `mem_size_i`, or any address presented with `fetch_vld_i` low, changes no flag and raises no output.
- R6: A `wdt_req_i` pulse sets the watchdog flag and raises `sys_rst_o` for one cycle, both at the next edge.
- R7: A watchdog reset leaves the power-on and hard-fault flags unchanged. A hard-fault reset leaves the power-on and watchdog flags unchanged. A power-on clears the watchdog and hard-fault flags.
- R8: A bus write (`bus_en_i` and `bus_we_i` high) to offset 0 clears each flag whose bit is 1 in the write data. The bits are: 0 power-on, 1 watchdog, 2 hard-fault. A 0 bit leaves its flag unchanged, and writes to any other offset change nothing.
- R9: If a flag-setting event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R10: `sys_rst_o` is never high in two consecutive cycles. A reset cause that arrives while `sys_rst_o` is high still sets its flag but produces no second pulse.
- R11: `bus_rdata_o` combinationally shows the flags at bits 0 to 2 when `bus_addr_i` is 0, with all upper bits 0. At any other offset it shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on event, active high, asynchronous; the block's only reset |
| wdt_req_i | input | 1 | Watchdog time-out reset request pulse |
| fetch_vld_i | input | 1 | Instruction fetch address valid |
| fetch_addr_i | input | PC_W | Instruction fetch address |
| mem_size_i | input | PC_W | Configured program memory size in bytes |
| hfie_i | input | 1 | Hard-fault interrupt enable |
| dbg_mode_i | input | 1 | Debug mode active |
| dbg_en_i | input | 1 | Debug enable level |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Register write (1) or read (0) |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | DATA_W | Write data, write-1-to-clear |
| bus_rdata_o | output | DATA_W | Read data |
| flag_por_o | output | 1 | Power-on flag |
| flag_wdt_o | output | 1 | Watchdog reset flag |
| flag_hf_o | output | 1 | Hard-fault flag |
| sys_rst_o | output | 1 | One-cycle system reset request |
| hf_irq_o | output | 1 | One-cycle hard-fault interrupt pulse |

## Verification
The assertions check four things on every cycle:
- The reset request never lasts more than one cycle.
- A hard fault seen in `SEQ_RUN` always produces the request.
- A debug-suppressed fault without a watchdog request never produces one.
- A set beats a clear, a flag with neither set nor clear holds its value, and a write-1 on bit 0 clears the power-on flag.

Some behaviour can only be shown by the bench scenarios:
- which flags survive each kind of reset,
- the merging of a cause that arrives during the pulse,
- the values read back over the bus,
- the absence of any effect from in-range fetches, invalid fetches and writes to other offsets.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_POR  = 0;
    localparam int FLAG_WDT  = 1;
    localparam int FLAG_HF   = 2;
    localparam logic [NUM_FLAGS-1:0] FLAG_POR_INIT = 3'b001;

    typedef enum logic [0:0] {
        SEQ_RUN  = 1'b0,
        SEQ_FIRE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rcs_fault_detect.sv
module rcs_fault_detect #(
    parameter int PC_W = 16
) (
    input  logic            fetch_vld_i,
    input  logic [PC_W-1:0] fetch_addr_i,
    input  logic [PC_W-1:0] mem_size_i,
    input  logic            hfie_i,
    input  logic            dbg_mode_i,
    input  logic            dbg_en_i,
    output logic            hf_flag_evt_o,
    output logic            hf_reset_evt_o,
    output logic            hf_irq_evt_o
);
    logic out_of_range;
    logic dbg_hold;

    always_comb begin
        out_of_range   = fetch_vld_i && (fetch_addr_i >= mem_size_i);
        dbg_hold       = dbg_mode_i && !dbg_en_i;
        hf_irq_evt_o   = out_of_range && hfie_i;
        hf_flag_evt_o  = out_of_range && !hfie_i;
        hf_reset_evt_o = hf_flag_evt_o && !dbg_hold;
    end
endmodule

// File: rtl/rcs_flags.sv
module rcs_flags #(
    parameter int                    NUM      = 3,
    parameter logic [NUM-1:0]        POR_INIT = '0
) (
    input  logic           clk,
    input  logic           rst_i,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flags_o
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        logic flag_q;

        always_ff @(posedge clk or posedge rst_i) begin
            if (rst_i) begin
                flag_q <= POR_INIT[i];
            end else if (set_i[i]) begin
                flag_q <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q <= 1'b0;
            end
        end

        assign flags_o[i] = flag_q;

        // R9: a set in the same cycle as a clear leaves the flag at 1
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst_i)
            set_i[i] |=> flags_o[i]);

        // R7: with neither a set nor a clear, the flag keeps its value
        p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst_i)
            (!set_i[i] && !clr_i[i]) |=> $stable(flags_o[i]));
    end
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
    import rcs_pkg::*;
(
    input  logic clk,
    input  logic rst_i,
    input  logic wdt_req_i,
    input  logic hf_reset_evt_i,
    input  logic hf_irq_evt_i,
    output logic sys_rst_o,
    output logic hf_irq_o
);
    seq_state_e state_q, state_nx;
    logic       rst_q;
    logic       irq_q;
    logic       cause;

    assign cause = wdt_req_i || hf_reset_evt_i;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SEQ_RUN:  if (cause) state_nx = SEQ_FIRE;
            SEQ_FIRE: state_nx = SEQ_RUN;
            default:  state_nx = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk or posedge rst_i) begin
        if (rst_i) begin
            state_q <= SEQ_RUN;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or posedge rst_i) begin
        if (rst_i) begin
            rst_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            rst_q <= (state_nx == SEQ_FIRE);
            irq_q <= hf_irq_evt_i;
        end
    end

    assign sys_rst_o = rst_q;
    assign hf_irq_o  = irq_q;

    // R10: the reset request lasts one cycle only
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst_i)
        sys_rst_o |=> !sys_rst_o);

    // R2: an unsuppressed fault seen while idle produces the request
    p_hf_reset_r2: assert property (@(posedge clk) disable iff (rst_i)
        (hf_reset_evt_i && state_q == SEQ_RUN) |=> sys_rst_o);
endmodule

// File: rtl/rcs_regif.sv
module rcs_regif #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NUM    = 3
) (
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [NUM-1:0]    flags_i,
    output logic [NUM-1:0]    clr_o,
    output logic [DATA_W-1:0] bus_rdata_o
);
    localparam logic [ADDR_W-1:0] STAT_OFS = '0;

    logic hit;
    logic unused_wdata_hi;

    assign hit             = (bus_addr_i == STAT_OFS);
    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NUM];

    always_comb begin
        clr_o       = '0;
        bus_rdata_o = '0;
        if (bus_en_i && bus_we_i && hit) begin
            clr_o = bus_wdata_i[NUM-1:0];
        end
        if (hit) begin
            bus_rdata_o[NUM-1:0] = flags_i;
        end
    end
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
    import rcs_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              wdt_req_i,
    input  logic              fetch_vld_i,
    input  logic [PC_W-1:0]   fetch_addr_i,
    input  logic [PC_W-1:0]   mem_size_i,
    input  logic              hfie_i,
    input  logic              dbg_mode_i,
    input  logic              dbg_en_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              flag_por_o,
    output logic              flag_wdt_o,
    output logic              flag_hf_o,
    output logic              sys_rst_o,
    output logic              hf_irq_o
);
    logic                 hf_flag_evt;
    logic                 hf_reset_evt;
    logic                 hf_irq_evt;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flags;

    rcs_fault_detect #(.PC_W(PC_W)) u_detect (
        .fetch_vld_i    (fetch_vld_i),
        .fetch_addr_i   (fetch_addr_i),
        .mem_size_i     (mem_size_i),
        .hfie_i         (hfie_i),
        .dbg_mode_i     (dbg_mode_i),
        .dbg_en_i       (dbg_en_i),
        .hf_flag_evt_o  (hf_flag_evt),
        .hf_reset_evt_o (hf_reset_evt),
        .hf_irq_evt_o   (hf_irq_evt)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_WDT] = wdt_req_i;
        set_vec[FLAG_HF]  = hf_flag_evt;
    end

    rcs_flags #(.NUM(NUM_FLAGS), .POR_INIT(FLAG_POR_INIT)) u_flags (
        .clk     (clk),
        .rst_i   (por_i),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    rcs_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM(NUM_FLAGS)) u_regif (
        .bus_en_i    (bus_en_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .flags_i     (flags),
        .clr_o       (clr_vec),
        .bus_rdata_o (bus_rdata_o)
    );

    rcs_seq u_seq (
        .clk            (clk),
        .rst_i          (por_i),
        .wdt_req_i      (wdt_req_i),
        .hf_reset_evt_i (hf_reset_evt),
        .hf_irq_evt_i   (hf_irq_evt),
        .sys_rst_o      (sys_rst_o),
        .hf_irq_o       (hf_irq_o)
    );

    assign flag_por_o = flags[FLAG_POR];
    assign flag_wdt_o = flags[FLAG_WDT];
    assign flag_hf_o  = flags[FLAG_HF];

    // R3: a debug-suppressed fault with no watchdog request gives no reset
    p_dbg_no_reset_r3: assert property (@(posedge clk) disable iff (por_i)
        (fetch_vld_i && fetch_addr_i >= mem_size_i && !hfie_i
         && dbg_mode_i && !dbg_en_i && !wdt_req_i) |=> !sys_rst_o);

    // R6: a watchdog request sets its flag
    p_wdt_flag_r6: assert property (@(posedge clk) disable iff (por_i)
        wdt_req_i |=> flag_wdt_o);

    // R8: writing 1 to bit 0 at offset 0 clears the power-on flag
    p_por_clear_r8: assert property (@(posedge clk) disable iff (por_i)
        (bus_en_i && bus_we_i && bus_addr_i == '0 && bus_wdata_i[0]) |=> !flag_por_o);

    // R4: an out-of-range fetch with the interrupt enabled pulses the interrupt
    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (por_i)
        (fetch_vld_i && fetch_addr_i >= mem_size_i && hfie_i) |=> hf_irq_o);
endmodule

// File: tb/tb_reset_cause_unit.sv
module tb_reset_cause_unit;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              por_i;
    logic              wdt_req_i;
    logic              fetch_vld_i;
    logic [PC_W-1:0]   fetch_addr_i;
    logic [PC_W-1:0]   mem_size_i;
    logic              hfie_i;
    logic              dbg_mode_i;
    logic              dbg_en_i;
    logic              bus_en_i;
    logic              bus_we_i;
    logic [ADDR_W-1:0] bus_addr_i;
    logic [DATA_W-1:0] bus_wdata_i;
    logic [DATA_W-1:0] bus_rdata_o;
    logic              flag_por_o;
    logic              flag_wdt_o;
    logic              flag_hf_o;
    logic              sys_rst_o;
    logic              hf_irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_cause_unit #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .por_i(por_i), .wdt_req_i(wdt_req_i),
        .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i),
        .mem_size_i(mem_size_i), .hfie_i(hfie_i), .dbg_mode_i(dbg_mode_i),
        .dbg_en_i(dbg_en_i), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .flag_por_o(flag_por_o),
        .flag_wdt_o(flag_wdt_o), .flag_hf_o(flag_hf_o),
        .sys_rst_o(sys_rst_o), .hf_irq_o(hf_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wdt_req_i   = 1'b0;
        fetch_vld_i = 1'b0;
        fetch_addr_i = '0;
        bus_en_i    = 1'b0;
        bus_we_i    = 1'b0;
        bus_addr_i  = '0;
        bus_wdata_i = '0;
    endtask

    // flags packed as {hf, wdt, por}
    function automatic logic [31:0] fl();
        return {29'd0, flag_hf_o, flag_wdt_o, flag_por_o};
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        cyc();
        idle();
    endtask

    task automatic fetch(input logic [PC_W-1:0] a, input logic v);
        fetch_vld_i = v; fetch_addr_i = a;
        cyc();
        idle();
    endtask

    task automatic t_power_on();
        por_i = 1'b1;
        cyc();
        chk("R1 flags in reset", fl(), 32'h1);
        chk("R1 rst in reset", {31'd0, sys_rst_o}, 0);
        chk("R1 irq in reset", {31'd0, hf_irq_o}, 0);
        por_i = 1'b0;
        cyc();
        chk("R1 flags after reset", fl(), 32'h1);
        bus_addr_i = '0;
        #1 chk("R11 read status", {24'd0, bus_rdata_o}, 32'h01);
        bus_addr_i = 4'd3;
        #1 chk("R11 other offset reads 0", {24'd0, bus_rdata_o}, 0);
        bus_addr_i = '0;
    endtask

    task automatic t_clear_rules();
        wr('0, 8'h00);
        chk("R8 write 0 keeps", fl(), 32'h1);
        wr(4'd1, 8'hFF);
        chk("R8 other offset ignored", fl(), 32'h1);
        wr('0, 8'h01);
        chk("R8 w1c clears por", fl(), 32'h0);
    endtask

    task automatic t_no_fault();
        fetch(16'h0FFF, 1'b1);
        chk("R5 in range", fl(), 0);
        chk("R5 no rst", {31'd0, sys_rst_o}, 0);
        fetch(16'hF000, 1'b0);
        chk("R5 invalid fetch", fl(), 0);
        chk("R5 invalid no rst", {31'd0, sys_rst_o}, 0);
    endtask

    task automatic t_hf_reset();
        fetch(16'h1000, 1'b1);
        chk("R2 hf flag", fl(), 32'h4);
        chk("R2 rst pulse", {31'd0, sys_rst_o}, 1);
        #1 chk("R11 read hf", {24'd0, bus_rdata_o}, 32'h04);
        cyc();
        chk("R10 rst drops", {31'd0, sys_rst_o}, 0);
    endtask

    task automatic t_wdt();
        wdt_req_i = 1'b1;
        cyc();
        idle();
        chk("R6 wdt flag, R7 hf kept", fl(), 32'h6);
        chk("R6 rst pulse", {31'd0, sys_rst_o}, 1);
        cyc();
        chk("R6 rst one cycle", {31'd0, sys_rst_o}, 0);
        fetch(16'h2000, 1'b1);
        chk("R7 hf reset keeps wdt", fl(), 32'h6);
        cyc();
        wr('0, 8'h06);
        chk("R8 clear wdt and hf", fl(), 0);
    endtask

    task automatic t_debug();
        dbg_mode_i = 1'b1; dbg_en_i = 1'b0;
        fetch(16'hFFFF, 1'b1);
        chk("R3 flag only", fl(), 32'h4);
        chk("R3 no rst", {31'd0, sys_rst_o}, 0);
        cyc();
        chk("R3 still no rst", {31'd0, sys_rst_o}, 0);
        dbg_en_i = 1'b1;
        fetch(16'hFFFF, 1'b1);
        chk("R3 debug enabled resets", {31'd0, sys_rst_o}, 1);
        dbg_mode_i = 1'b0; dbg_en_i = 1'b0;
        cyc();
        wr('0, 8'h04);
        chk("R8 clear hf", fl(), 0);
    endtask

    task automatic t_irq();
        hfie_i = 1'b1;
        fetch(16'h1800, 1'b1);
        chk("R4 irq pulse", {31'd0, hf_irq_o}, 1);
        chk("R4 no flag", fl(), 0);
        chk("R4 no rst", {31'd0, sys_rst_o}, 0);
        cyc();
        chk("R4 irq one cycle", {31'd0, hf_irq_o}, 0);
        hfie_i = 1'b0;
    endtask

    task automatic t_set_wins();
        fetch(16'h1000, 1'b1);
        cyc();
        wdt_req_i = 1'b1;
        bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = '0; bus_wdata_i = 8'h06;
        cyc();
        idle();
        chk("R9 wdt set beats clear, hf cleared", fl(), 32'h2);
        cyc();
        wr('0, 8'h02);
        chk("R9 later clear works", fl(), 0);
    endtask

    task automatic t_merge();
        wdt_req_i = 1'b1;
        cyc();
        idle();
        chk("R10 first pulse", {31'd0, sys_rst_o}, 1);
        fetch(16'h3000, 1'b1);
        chk("R10 no second pulse", {31'd0, sys_rst_o}, 0);
        chk("R10 merged flags", fl(), 32'h6);
        cyc();
        chk("R10 stays low", {31'd0, sys_rst_o}, 0);
    endtask

    task automatic t_power_again();
        por_i = 1'b1;
        #1;
        chk("R7 por clears wdt and hf", fl(), 32'h1);
        cyc();
        por_i = 1'b0;
        cyc();
        chk("R1 flags after second power-on", fl(), 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        por_i = 1'b1;
        hfie_i = 1'b0; dbg_mode_i = 1'b0; dbg_en_i = 1'b0;
        mem_size_i = 16'h1000;
        idle();
        @(negedge clk);
        t_power_on();
        t_clear_rules();
        t_no_fault();
        t_hf_reset();
        t_wdt();
        t_debug();
        t_irq();
        t_set_wins();
        t_merge();
        t_power_again();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule